// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Host Controller

This block sits between internal logic and an asynchronous 16-bit pseudo-static RAM. The host issues one request at a time over a valid/ready handshake. The controller turns each request into a timed sequence on the memory's control pins. Five request kinds exist: word or byte read, word or byte write, loading the memory's configuration register, entering the low-power state, and leaving it.

Every read, write or configuration load runs as three phases. First comes an address setup phase. Next comes a strobe phase whose length is a parameter, sized so that it covers the memory's access time at the system clock. Last comes a hold phase with the strobes released. Read data is sampled on the last strobe cycle. Lanes the host did not select are returned as zero.

A configuration load sends its value on the address lines, with the data bus released and the sleep pin held low. The controller keeps a shadow of the configuration bit that selects the low-power kind. When the host asks for low-power entry, that bit decides whether the memory goes to partial-array refresh or to deep power-down, and the controller reports which one on `lp_deep`. Leaving deep power-down holds the controller busy for a parameterised wake-up time. Between requests the controller keeps every pin static, so that the memory can reach standby current.

Top module: `psram_host_ctrl`

## Requirements
- R1: After reset, chip enable, write enable, output enable, both byte enables and the sleep pin are high. `mem_dq_oe` is low, `req_ready` is high and `done` is low.
- R2: A read (req_op 0) accepted at a clock edge gives the following pattern. For SETUP_CYC cycles chip enable is low and the strobes are high. For STROBE_CYC cycles output enable is low and write enable is high. For HOLD_CYC cycles the strobes are high again. In the cycle after that, chip enable is high and `done` is high for one cycle, with `rdata` valid.
- R3: Byte lanes follow `req_be`. Bit 0 pulls the lower-lane enable low during the strobe and covers bits 7:0. Bit 1 pulls the upper-lane enable low and covers bits 15:8. A write changes only the selected lanes, and a read returns zero in the unselected lanes of `rdata`.
- R4: A write (req_op 1) follows the timing of R2, but write enable is low during the strobe and output enable stays high. `mem_dq_oe` is high exactly during the strobe and hold phases, with `mem_dq_out` equal to the write data.
- R5: A configuration load (req_op 2) drives the value on `mem_addr` and keeps the sleep pin low for all three phases. Write enable is low during the strobe. Output enable and both byte enables stay high, and `mem_dq_oe` stays low.
- R6: Low-power entry (req_op 3) from idle drives the sleep pin low with chip enable high. `done` is high in the next cycle. `lp_deep` equals 1 when bit 4 of the last loaded configuration value was 0 (deep power-down), and 0 when that bit was 1 (partial-array refresh). The bit is 1 after reset.
- R7: Exit (req_op 4) while asleep releases the sleep pin in the next cycle. After partial-array refresh, `done` comes in that same cycle. After deep power-down, `req_ready` stays low for WAKE_CYC cycles and `done` comes in the cycle after them.
- R8: From the acceptance of a read, write or configuration load until its `done`, `req_ready` is low, and requests presented in that time have no effect.
- R9: While asleep, every request other than exit is ignored: the pins hold and no `done` follows. While idle, exit and the unused codes 5 to 7 are ignored.
- R10: While idle with no request, the address and all control pins hold their values whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 3 | 0 read, 1 write, 2 configuration load, 3 sleep entry, 4 sleep exit |
| req_addr | input | AW | Word address, or the configuration value |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane select: bit 0 low byte, bit 1 high byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data, unselected lanes zero |
| lp_deep | output | 1 | Mode of the last sleep entry: 1 deep power-down, 0 partial refresh |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_zz_n | output | 1 | Memory sleep pin, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
Count cycles from the edge that accepts a request as cycle 0. The pin pattern of a read, write or load is then due cycle by cycle: setup in cycles 0 to SETUP_CYC-1, strobe in the next STROBE_CYC cycles, hold in the next HOLD_CYC cycles, and `done` with `rdata` exactly one cycle after the hold. Sleep entry and partial-refresh exit give `done` in cycle 0. Deep exit gives `done` in cycle WAKE_CYC. The bench drives at the falling edge and compares at every falling edge after acceptance against the pattern it expects for that cycle number. A cycle that is early, late or has a wrong pin therefore fails the whole sequence check.

// File: rtl/psram_host_ctrl.sv
module psram_host_ctrl #(
  parameter int AW         = 22,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 5,
  parameter int HOLD_CYC   = 1,
  parameter int WAKE_CYC   = 150,
  parameter bit PAR_AT_RST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          done,
  output logic [15:0]   rdata,
  output logic          lp_deep,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic          mem_zz_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  localparam logic [2:0] OP_RD   = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_CFG  = 3'd2;
  localparam logic [2:0] OP_SLP  = 3'd3;
  localparam logic [2:0] OP_WAKE = 3'd4;
  localparam int MODE_BIT = 4;
  localparam int M1   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int M2   = (HOLD_CYC > WAKE_CYC) ? HOLD_CYC : WAKE_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_SLEEP, S_WAKE} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [2:0]     op_q;
  logic [1:0]     be_q;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q;
  logic           par_mode;

  wire accept  = req_valid && req_ready;
  wire cnt_end = (cnt == '0);
  wire active  = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  wire strobe  = (st == S_STROBE);
  wire is_rd   = (op_q == OP_RD);
  wire is_wr   = (op_q == OP_WR);
  wire is_cfg  = (op_q == OP_CFG);

  assign req_ready  = (st == S_IDLE) || (st == S_SLEEP);
  assign mem_ce_n   = !active;
  assign mem_we_n   = !(strobe && (is_wr || is_cfg));
  assign mem_oe_n   = !(strobe && is_rd);
  assign mem_lb_n   = !(strobe && !is_cfg && be_q[0]);
  assign mem_ub_n   = !(strobe && !is_cfg && be_q[1]);
  assign mem_zz_n   = !((active && is_cfg) || (st == S_SLEEP));
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = is_wr && (strobe || (st == S_HOLD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      op_q     <= OP_RD;
      be_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata    <= '0;
      done     <= 1'b0;
      lp_deep  <= 1'b0;
      par_mode <= PAR_AT_RST;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (accept && req_op <= OP_CFG) begin
            op_q    <= req_op;
            be_q    <= req_be;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cnt     <= CW'(SETUP_CYC - 1);
            st      <= S_SETUP;
          end else if (accept && req_op == OP_SLP) begin
            st      <= S_SLEEP;
            done    <= 1'b1;
            lp_deep <= !par_mode;
          end
        end
        S_SETUP: begin
          if (cnt_end) begin
            cnt <= CW'(STROBE_CYC - 1);
            st  <= S_STROBE;
          end else cnt <= cnt - CW'(1);
        end
        S_STROBE: begin
          if (cnt_end) begin
            cnt <= CW'(HOLD_CYC - 1);
            st  <= S_HOLD;
            if (is_rd) rdata <= mem_dq_in & {{8{be_q[1]}}, {8{be_q[0]}}};
            if (is_cfg) par_mode <= addr_q[MODE_BIT];
          end else cnt <= cnt - CW'(1);
        end
        S_HOLD: begin
          if (cnt_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt - CW'(1);
        end
        S_SLEEP: begin
          if (accept && req_op == OP_WAKE) begin
            if (lp_deep) begin
              cnt <= CW'(WAKE_CYC - 1);
              st  <= S_WAKE;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        S_WAKE: begin
          if (cnt_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_bus_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n && mem_zz_n));

  a_r2_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st == S_IDLE && req_op <= OP_CFG) |=> !req_ready);

  a_r8_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r10_addr_static: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> $stable(mem_addr));

  a_r5_load_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_zz_n && !mem_ce_n) |-> (mem_oe_n && !mem_dq_oe && mem_lb_n && mem_ub_n));

  a_r3_lanes_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lb_n || !mem_ub_n) |-> (!mem_ce_n && mem_zz_n));

endmodule

// File: tb/test_psram_host_ctrl.sv
`timescale 1ns/1ps
module test_psram_host_ctrl;
  localparam int AW = 8, S = 1, T = 3, H = 1, W = 6;
  localparam int L = S + T + H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic done, lp_deep, ce_n, we_n, oe_n, ub_n, lb_n, zz_n, dq_oe;
  logic [15:0] rdata, dq_out, dq_in;
  logic [AW-1:0] maddr;

  logic [15:0] mem [256];
  logic [15:0] expm [256];
  logic [AW-1:0] mcfg = '0;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  psram_host_ctrl #(.AW(AW), .SETUP_CYC(S), .STROBE_CYC(T), .HOLD_CYC(H), .WAKE_CYC(W)) i_psram_host_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .done(done), .rdata(rdata),
    .lp_deep(lp_deep), .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_ub_n(ub_n),
    .mem_lb_n(lb_n), .mem_zz_n(zz_n), .mem_addr(maddr), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe),
    .mem_dq_in(dq_in));

  assign dq_in = !oe_n ? mem[maddr] : 16'hDEAD;

  always @(posedge clk) begin
    if (!ce_n && !we_n && zz_n && dq_oe) begin
      if (!lb_n) mem[maddr][7:0]  <= dq_out[7:0];
      if (!ub_n) mem[maddr][15:8] <= dq_out[15:8];
    end
    if (!ce_n && !we_n && !zz_n) mcfg <= maddr;
  end

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic access(input logic [2:0] op, input logic [7:0] a, input logic [15:0] wd,
                        input logic [1:0] be, input bit hold_valid,
                        output logic [15:0] rd, output bit ok);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    if (hold_valid) begin req_addr = a ^ 8'hFF; req_wdata = ~wd; end
    else req_valid = 1'b0;
    ok = 1'b1;
    rd = '0;
    for (int c = 0; c <= L; c++) begin
      bit stb, inseq;
      @(negedge clk);
      if (hold_valid && c == L - 1) req_valid = 1'b0;
      stb = (c >= S) && (c < S + T);
      inseq = (c < L);
      if (ce_n  !== !inseq) ok = 1'b0;
      if (we_n  !== !(stb && op != 3'd0)) ok = 1'b0;
      if (oe_n  !== !(stb && op == 3'd0)) ok = 1'b0;
      if (lb_n  !== !(stb && op != 3'd2 && be[0])) ok = 1'b0;
      if (ub_n  !== !(stb && op != 3'd2 && be[1])) ok = 1'b0;
      if (zz_n  !== !(inseq && op == 3'd2)) ok = 1'b0;
      if (dq_oe !== (op == 3'd1 && c >= S && inseq)) ok = 1'b0;
      if (dq_oe && dq_out !== wd) ok = 1'b0;
      if (maddr !== a) ok = 1'b0;
      if (done !== (c == L)) ok = 1'b0;
      if (req_ready !== (c == L)) ok = 1'b0;
      if (c == L) rd = rdata;
    end
  endtask

  task automatic pulse_req(input logic [2:0] op);
    @(negedge clk);
    req_valid = 1'b1; req_op = op;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not end, got %0d expected 0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk({ce_n, we_n, oe_n, ub_n, lb_n, zz_n} == 6'h3F, "R1", "pins after reset",
        {ce_n, we_n, oe_n, ub_n, lb_n, zz_n}, 6'h3F);
    chk(dq_oe == 1'b0 && req_ready == 1'b1 && done == 1'b0, "R1", "oe/ready/done",
        {dq_oe, req_ready, done}, 3'b010);
    rst_n = 1'b1;

    // R4 full-word writes over every address
    for (int a = 0; a < 256; a++) begin
      logic [15:0] wd;
      wd = 16'(a * 257) ^ 16'hA5C3;
      access(3'd1, 8'(a), wd, 2'b11, 1'b0, rd, ok);
      expm[a] = wd;
      chk(ok, "R4", "write sequence", 32'(a), 32'(a));
    end

    // R2 and R3 reads with every lane mask
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic [15:0] e;
        access(3'd0, 8'(a), 16'h0, 2'(b), 1'b0, rd, ok);
        e = expm[a] & lane_mask(2'(b));
        chk(ok, "R2", "read sequence", 32'(a), 32'(b));
        chk(rd == e, "R3", "read lanes", rd, e);
      end
    end

    // R3 single-lane writes
    for (int a = 0; a < 64; a++) begin
      logic [1:0] be;
      logic [15:0] wd;
      be = (a % 2 == 0) ? 2'b01 : 2'b10;
      wd = 16'(a * 4099) ^ 16'h3C5A;
      access(3'd1, 8'(a), wd, be, 1'b0, rd, ok);
      expm[a] = (expm[a] & ~lane_mask(be)) | (wd & lane_mask(be));
      chk(ok, "R3", "lane write sequence", 32'(a), 32'(be));
      access(3'd0, 8'(a), 16'h0, 2'b11, 1'b0, rd, ok);
      chk(rd == expm[a], "R3", "lane write readback", rd, expm[a]);
    end

    // R8 requests held during a busy access are dropped
    access(3'd1, 8'h12, 16'hBEEF, 2'b11, 1'b1, rd, ok);
    expm[8'h12] = 16'hBEEF;
    chk(ok, "R8", "busy sequence", {31'd0, ok}, 32'd1);
    access(3'd0, 8'h12 ^ 8'hFF, 16'h0, 2'b11, 1'b0, rd, ok);
    chk(rd == expm[8'h12 ^ 8'hFF], "R8", "second request not written", rd, expm[8'h12 ^ 8'hFF]);
    access(3'd0, 8'h12, 16'h0, 2'b11, 1'b0, rd, ok);
    chk(rd == 16'hBEEF, "R8", "first request written", rd, 16'hBEEF);

    // R6 partial refresh after reset, R7 fast exit
    pulse_req(3'd3);
    @(negedge clk);
    chk(done && !lp_deep && !zz_n && ce_n, "R6", "entry after reset {done,deep,zz,ce}",
        {done, lp_deep, zz_n, ce_n}, 4'b1001);
    pulse_req(3'd4);
    @(negedge clk);
    chk(done && zz_n && ce_n && req_ready, "R7", "partial exit {done,zz,ready}",
        {done, zz_n, req_ready}, 3'b111);

    // R5 configuration load selecting deep power-down
    access(3'd2, 8'h0B, 16'h0, 2'b11, 1'b0, rd, ok);
    chk(ok, "R5", "load sequence", {31'd0, ok}, 32'd1);
    chk(mcfg == 8'h0B, "R5", "value on address bus", mcfg, 8'h0B);

    // R6 deep entry
    pulse_req(3'd3);
    @(negedge clk);
    chk(done && lp_deep && !zz_n && ce_n, "R6", "deep entry {done,deep,zz,ce}",
        {done, lp_deep, zz_n, ce_n}, 4'b1101);

    // R9 non-exit requests while asleep
    begin
      bit quiet;
      quiet = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(k);
      end
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 6; k++) begin
        if (done || zz_n || !ce_n || !we_n || !oe_n || dq_oe) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R9", "sleep ignores other ops", {31'd0, quiet}, 32'd1);
    end

    // R7 deep exit wake-up delay
    pulse_req(3'd4);
    begin
      bit okw;
      okw = 1'b1;
      for (int c = 0; c <= W; c++) begin
        @(negedge clk);
        if (req_ready !== (c == W) || done !== (c == W) || !zz_n) okw = 1'b0;
      end
      chk(okw, "R7", "deep wake timing", {31'd0, okw}, 32'd1);
    end

    // R6 configuration back to partial refresh
    access(3'd2, 8'h10, 16'h0, 2'b11, 1'b0, rd, ok);
    chk(ok && mcfg == 8'h10, "R5", "second load", mcfg, 8'h10);
    pulse_req(3'd3);
    @(negedge clk);
    chk(done && !lp_deep, "R6", "partial after load {done,deep}", {done, lp_deep}, 2'b10);
    pulse_req(3'd4);
    @(negedge clk);
    chk(done && req_ready, "R7", "partial exit again", {done, req_ready}, 2'b11);

    // R9 idle ignores exit and unused codes
    for (int op = 4; op < 8; op++) begin
      bit q;
      q = 1'b1;
      pulse_req(3'(op));
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (done || !ce_n || !zz_n || !req_ready) q = 1'b0;
      end
      chk(q, "R9", "idle ignores op", 32'(op), 32'(op));
    end

    // R10 idle pins static under changing request inputs
    begin
      logic [AW-1:0] a0;
      bit st;
      @(negedge clk);
      a0 = maddr;
      st = 1'b1;
      for (int k = 0; k < 12; k++) begin
        req_addr = 8'(k * 37); req_op = 3'(k); req_wdata = 16'(k * 911); req_be = 2'(k);
        @(negedge clk);
        if (maddr !== a0 || {ce_n, we_n, oe_n, ub_n, lb_n, zz_n} !== 6'h3F || dq_oe) st = 1'b0;
      end
      chk(st, "R10", "idle pins static", maddr, a0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule